// File: doc/BRIEF.md
# Four-Level Channel Grant Arbiter

This block chooses one active channel out of a set of pending transfer requests for a multi-channel DMA engine. Every channel is assigned to one of four priority levels through a 2-bit level input. Between levels, the highest level that has a request always wins. Inside a level, a per-level mode bit picks the scheme. Fixed-order arbitration gives the win to the lowest-numbered requester. Rotating arbitration starts the search just above a stored channel number and wraps around.

A 32-bit control word holds one byte per level. In byte n, bit 7 is the rotating-mode enable for level n and bits 4:0 hold the level-n channel pointer. Software can read the word and write it. A write-lock input blocks all writes. When a grant is accepted at a level that is in rotating mode, the hardware stores the winning channel in that level's pointer field. The pointer is visible to software and keeps its value when rotating mode is switched off.

The grant is combinational from the current requests and the stored control word. When nothing is requesting, the last granted index is held on the output.

Top module: `dma_level_arbiter`

## Requirements
- R1: After reset the control readback is 0x00000000, grant-valid is low and the grant index is 0.
- R2: A write with the lock low loads bit 7 and bits 4:0 of every byte. Bits 6:5 of every byte always read as zero, whatever was written.
- R3: While the write-lock input is high, a write leaves the control readback unchanged.
- R4: Level 3 is the highest level. The granted channel belongs to the highest level among the requesting channels.
- R5: In a level whose mode bit (bit 7 of its byte) is 0, the lowest-numbered requesting channel of that level wins, whatever value its pointer field holds.
- R6: In a level whose mode bit is 1, the winner is the first requesting channel of that level with an index greater than the pointer. If there is none, the winner is the lowest requesting channel of that level.
- R7: When grant-accept is high while grant-valid is high and the winner's level has its mode bit set, that level's pointer field reads back the granted index from the next cycle on. A level with its mode bit clear is not updated.
- R8: Clearing a level's mode bit by a write that keeps the field value leaves the pointer unchanged, and that level then arbitrates in fixed order.
- R9: If a software write and a hardware pointer update hit the same level in the same cycle, the pointer takes the hardware value. The mode bit takes the written value.
- R10: When no channel is requesting, grant-valid is low and the grant index keeps its last value.
- R11: Grant-valid is high in exactly the cycles in which at least one request bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_CH | Per-channel request bits |
| lvl_i | input | 2*NUM_CH | Priority level of channel c in bits 2c+1:2c |
| accept_i | input | 1 | Grant-accept strobe |
| wr_en_i | input | 1 | Control word write enable |
| wr_data_i | input | 32 | Control word write data |
| wr_lock_i | input | 1 | Write protection, high blocks writes |
| gnt_valid_o | output | 1 | A channel is granted |
| gnt_idx_o | output | 5 | Granted channel index |
| ctrl_rd_o | output | 32 | Control word readback |

## Verification
The hardest case to reach is a software write and a hardware pointer update on the same level in the same cycle. Close behind it is a rotation whose stored pointer is above every requester, so the search has to wrap. Directed sequences first load a pointer, enable rotating mode and accept grants back to back, which walks the wrap. They then raise write-enable together with grant-accept on that level. After that, a long random phase mixes level maps, accepts, locked and unlocked writes and idle cycles. A behavioural reference model is compared with the outputs on every cycle.

// File: rtl/dla_pkg.sv
package dla_pkg;
  localparam int LVL_N  = 4;
  localparam int LVL_W  = 2;
  localparam int IDX_W  = 5;
  localparam int BYTE_W = 8;
  localparam int MODE_BIT = 7;
  localparam int WORD_W = LVL_N * BYTE_W;

  typedef struct packed {
    logic             rr_en;
    logic [IDX_W-1:0] ptr;
  } lvl_cfg_t;

  // lowest set bit: {found, index}
  function automatic logic [IDX_W:0] find_low(input logic [31:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/dla_rst_sync.sv
module dla_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dla_ctrl_reg.sv
module dla_ctrl_reg
  import dla_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic                    wr_lock_i,
  input  logic [WORD_W-1:0]       wr_data_i,
  input  logic                    upd_en_i,
  input  logic [LVL_W-1:0]        upd_lvl_i,
  input  logic [IDX_W-1:0]        upd_idx_i,
  output lvl_cfg_t [LVL_N-1:0]    cfg_o,
  output logic [WORD_W-1:0]       rd_o
);
  lvl_cfg_t [LVL_N-1:0] cfg_q, cfg_d;
  logic                 wr_ok;

  assign wr_ok = wr_en_i & ~wr_lock_i;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_ok) begin
      for (int l = 0; l < LVL_N; l++) begin
        cfg_d[l].rr_en = wr_data_i[l*BYTE_W + MODE_BIT];
        cfg_d[l].ptr   = wr_data_i[l*BYTE_W +: IDX_W];
      end
    end
    // hardware pointer update wins over a same-cycle write
    if (upd_en_i) cfg_d[upd_lvl_i].ptr = upd_idx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  genvar g;
  generate
    for (g = 0; g < LVL_N; g++) begin : g_rd
      assign rd_o[g*BYTE_W + MODE_BIT]          = cfg_q[g].rr_en;
      assign rd_o[g*BYTE_W + IDX_W +: 2]        = 2'b00;
      assign rd_o[g*BYTE_W +: IDX_W]            = cfg_q[g].ptr;
    end
  endgenerate

  assign cfg_o = cfg_q;
endmodule

// File: rtl/dla_level_pick.sv
module dla_level_pick
  import dla_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] req_i,
  input  lvl_cfg_t          cfg_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [NUM_CH-1:0] above;
  logic [NUM_CH-1:0] upper_req;
  logic [IDX_W:0]    low_all, low_upper;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      above[c] = (IDX_W'(c) > cfg_i.ptr);
    end
  end

  assign upper_req = req_i & above;
  assign low_all   = find_low(32'(req_i));
  assign low_upper = find_low(32'(upper_req));
  assign any_o     = low_all[IDX_W];

  always_comb begin
    if (cfg_i.rr_en && low_upper[IDX_W]) idx_o = low_upper[IDX_W-1:0];
    else                                 idx_o = low_all[IDX_W-1:0];
  end
endmodule

// File: rtl/dla_level_select.sv
module dla_level_select
  import dla_pkg::*;
(
  input  logic [LVL_N-1:0]            any_i,
  input  logic [LVL_N-1:0][IDX_W-1:0] idx_i,
  output logic                        valid_o,
  output logic [LVL_W-1:0]            lvl_o,
  output logic [IDX_W-1:0]            idx_o
);
  always_comb begin
    valid_o = 1'b0;
    lvl_o   = '0;
    idx_o   = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (any_i[l]) begin
        valid_o = 1'b1;
        lvl_o   = LVL_W'(l);
        idx_o   = idx_i[l];
      end
    end
  end
endmodule

// File: rtl/dma_level_arbiter.sv
module dma_level_arbiter
  import dla_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     req_i,
  input  logic [2*NUM_CH-1:0]   lvl_i,
  input  logic                  accept_i,
  input  logic                  wr_en_i,
  input  logic [31:0]           wr_data_i,
  input  logic                  wr_lock_i,
  output logic                  gnt_valid_o,
  output logic [4:0]            gnt_idx_o,
  output logic [31:0]           ctrl_rd_o
);
  logic                            rst_q;
  lvl_cfg_t [LVL_N-1:0]            cfg;
  logic [LVL_N-1:0][NUM_CH-1:0]    lvl_req;
  logic [LVL_N-1:0]                lvl_any;
  logic [LVL_N-1:0][IDX_W-1:0]     lvl_idx;
  logic                            win_valid;
  logic [LVL_W-1:0]                win_lvl;
  logic [IDX_W-1:0]                win_idx;
  logic                            upd_en;
  logic [IDX_W-1:0]                hold_q, hold_d;
  logic                            hold_en;

  dla_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  genvar gl, gc;
  generate
    for (gl = 0; gl < LVL_N; gl++) begin : g_lvl
      for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
        assign lvl_req[gl][gc] = req_i[gc] & (lvl_i[2*gc +: 2] == LVL_W'(gl));
      end
      dla_level_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req_i (lvl_req[gl]),
        .cfg_i (cfg[gl]),
        .any_o (lvl_any[gl]),
        .idx_o (lvl_idx[gl])
      );
    end
  endgenerate

  dla_level_select u_sel (
    .any_i   (lvl_any),
    .idx_i   (lvl_idx),
    .valid_o (win_valid),
    .lvl_o   (win_lvl),
    .idx_o   (win_idx)
  );

  assign upd_en = accept_i & win_valid & cfg[win_lvl].rr_en;

  dla_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_q),
    .wr_en_i   (wr_en_i),
    .wr_lock_i (wr_lock_i),
    .wr_data_i (wr_data_i),
    .upd_en_i  (upd_en),
    .upd_lvl_i (win_lvl),
    .upd_idx_i (win_idx),
    .cfg_o     (cfg),
    .rd_o      (ctrl_rd_o)
  );

  // last-grant hold register
  assign hold_en = win_valid;
  assign hold_d  = win_idx;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign gnt_valid_o = win_valid;
  assign gnt_idx_o   = win_valid ? win_idx : hold_q;
endmodule

// File: rtl/dla_checker.sv
module dla_checker #(
  parameter int NUM_CH = 8
) (
  input logic                clk,
  input logic                rst_q,
  input logic [NUM_CH-1:0]   req_i,
  input logic [2*NUM_CH-1:0] lvl_i,
  input logic                accept_i,
  input logic                wr_lock_i,
  input logic                gnt_valid_o,
  input logic [4:0]          gnt_idx_o,
  input logic [31:0]         ctrl_rd_o
);
  logic [1:0] wl;
  logic       win_req;
  logic       win_rr;

  function automatic logic [4:0] fld(input logic [31:0] r, input logic [1:0] l);
    return r[int'(l)*8 +: 5];
  endfunction

  always_comb begin
    wl      = '0;
    win_req = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (5'(c) == gnt_idx_o) begin
        wl      = lvl_i[2*c +: 2];
        win_req = req_i[c];
      end
    end
    win_rr = ctrl_rd_o[int'(wl)*8 + 7];
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (ctrl_rd_o & 32'h6060_6060) == 32'h0);

  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_lock_i && !accept_i) |=> $stable(ctrl_rd_o));

  assert_winner_requests_R4: assert property (@(posedge clk) disable iff (!rst_q)
    gnt_valid_o |-> win_req);

  assert_ptr_update_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (accept_i && gnt_valid_o && win_rr) |=> fld(ctrl_rd_o, $past(wl)) == $past(gnt_idx_o));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !gnt_valid_o |-> $stable(gnt_idx_o));

  assert_valid_any_R11: assert property (@(posedge clk) disable iff (!rst_q)
    gnt_valid_o == (|req_i));
endmodule

bind dma_level_arbiter dla_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .req_i       (req_i),
  .lvl_i       (lvl_i),
  .accept_i    (accept_i),
  .wr_lock_i   (wr_lock_i),
  .gnt_valid_o (gnt_valid_o),
  .gnt_idx_o   (gnt_idx_o),
  .ctrl_rd_o   (ctrl_rd_o)
);

// File: tb/tb_dma_level_arbiter.sv
`timescale 1ns/1ps
module tb_dma_level_arbiter;
  localparam int N = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req;
  logic [2*N-1:0]  lvl;
  logic            accept, wr_en, wr_lock;
  logic [31:0]     wr_data;
  logic            gnt_valid;
  logic [4:0]      gnt_idx;
  logic [31:0]     ctrl_rd;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  int m_rr[4];
  int m_ptr[4];
  int m_hold;

  always #2 clk = ~clk;

  dma_level_arbiter #(.NUM_CH(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_i(lvl), .accept_i(accept),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_lock_i(wr_lock),
    .gnt_valid_o(gnt_valid), .gnt_idx_o(gnt_idx), .ctrl_rd_o(ctrl_rd)
  );

  function automatic int chan_lvl(int c);
    return int'(lvl[2*c +: 2]);
  endfunction

  task automatic model_pick(output bit v, output int idx, output int lv);
    v = 0; idx = m_hold; lv = 0;
    for (int l = 3; l >= 0 && !v; l--) begin
      int first = -1;
      int up = -1;
      for (int c = 0; c < N; c++) begin
        if (req[c] && chan_lvl(c) == l) begin
          if (first < 0) first = c;
          if (up < 0 && c > m_ptr[l]) up = c;
        end
      end
      if (first >= 0) begin
        v = 1; lv = l;
        idx = (m_rr[l] != 0 && up >= 0) ? up : first;
      end
    end
  endtask

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int l = 0; l < 4; l++) begin
      w[l*8+7]   = (m_rr[l] != 0);
      w[l*8 +: 5] = 5'(m_ptr[l]);
    end
    return w;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock: compare before the edge, then advance the model
  task automatic cyc(string tag);
    bit v; int idx, lv; bit hw;
    #1;
    model_pick(v, idx, lv);
    check("R11 valid", int'(gnt_valid), int'(v));
    check(v ? tag : "R10 hold", int'(gnt_idx), idx);
    check(tag, int'(ctrl_rd), int'(model_word()));
    @(posedge clk);
    hw = accept && v && (m_rr[lv] != 0);
    if (wr_en && !wr_lock) begin
      for (int l = 0; l < 4; l++) begin
        m_rr[l] = int'(wr_data[l*8+7]);
        if (!(hw && l == lv)) m_ptr[l] = int'(wr_data[l*8 +: 5]);
      end
    end
    if (hw) m_ptr[lv] = idx;
    if (v) m_hold = idx;
    @(negedge clk);
    accept = 0; wr_en = 0;
  endtask

  task automatic write(logic [31:0] d, string tag);
    wr_data = d; wr_en = 1;
    cyc(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; req = '0; lvl = '0; accept = 0; wr_en = 0; wr_data = '0; wr_lock = 0;
    for (int l = 0; l < 4; l++) begin m_rr[l] = 0; m_ptr[l] = 0; end
    m_hold = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd", int'(ctrl_rd), 0);
    check("R1 valid", int'(gnt_valid), 0);
    check("R1 idx", int'(gnt_idx), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cyc("R1");

    // R2: reserved bits read zero
    write(32'hFFFF_FFFF, "R2");
    cyc("R2");
    // R3: locked write ignored
    wr_lock = 1;
    write(32'h0000_0000, "R3");
    cyc("R3");
    wr_lock = 0;
    write(32'h0000_0000, "R3 unlock");

    // level map: ch0:0 ch1:2 ch2:1 ch3:0 ch4:1 ch5:2 ch6:0 ch7:3
    lvl = {2'd3, 2'd0, 2'd2, 2'd1, 2'd0, 2'd1, 2'd2, 2'd0};
    req = 8'b1111_1111; cyc("R4");
    req = 8'b0111_1111; cyc("R4");
    req = 8'b0101_1101; cyc("R4");
    req = 8'b0100_1000; cyc("R5");
    // R5: non-zero pointer in fixed mode has no effect
    write(32'h0000_0005, "R5");
    req = 8'b0100_1001; accept = 1; cyc("R5");
    cyc("R5");
    // R6/R7: rotating on level 0 from pointer 5
    write(32'h0000_0085, "R6");
    for (int k = 0; k < 5; k++) begin
      accept = 1; cyc("R6 R7");
    end
    // pointer beyond all requesters wraps
    req = 8'b0000_1001; write(32'h0000_0087, "R6");
    accept = 1; cyc("R6");
    cyc("R6");
    // R8: clear mode keeping field
    write(ctrl_rd & 32'hFFFF_FF7F, "R8");
    accept = 1; cyc("R8");
    cyc("R8");
    // R9: write and hardware update same cycle
    write(32'h0000_0080, "R9");
    req = 8'b0100_1001; accept = 1; wr_en = 1; wr_data = 32'h0000_0082;
    cyc("R9");
    cyc("R9");
    // R10: idle hold
    req = '0; cyc("R10"); cyc("R10");
    req = 8'b1000_0000; cyc("R10"); req = '0; cyc("R10");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 25 == 0) lvl = 16'($urandom);
      req = 8'($urandom);
      if (($urandom & 3) == 0) req = '0;
      accept = ($urandom & 1);
      wr_lock = (($urandom % 3) == 0);
      if (($urandom & 15) == 0) begin
        wr_en = 1; wr_data = $urandom;
      end
      cyc("R4 R5 R6 R7 R9");
    end
    wr_lock = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule